// File: doc/BRIEF.md
# VRAM Block-Copy DMA Engine

This engine moves words around inside video RAM without processor help. Register decode happens elsewhere and hands the engine the current values of its source, destination, length, control and sprite-table-base registers, plus one-cycle start strobes. The engine owns the single VRAM port. It moves each word in two cycles: a read cycle that presents the source address, then a write cycle that stores the returned data at the destination address.

A second mode fills a separate 256-entry sprite attribute store from a VRAM window. That copy is armed only by a vertical-blank trigger pulse. At the pulse it runs if software requested it, or if the auto-repeat control bit is set. The window base must not exceed 0x7F00. Completion of either copy can raise a sticky status flag and the interrupt line. The flags stay set until the clear strobe.

Top module: `vram_dma`

## Requirements
- R1: After reset `busy_o`, `vram_we_o`, `sat_we_o`, `blk_done_o`, `sat_done_o`, `sat_seen_o` and `irq_o` are all 0.
- R2: A pulse on `blk_start_i` with `len_i` = N (N < 0xFFFF) copies N+1 words. Each word takes one read cycle, which drives the source address with `vram_we_o` = 0. The next cycle is a write cycle, which drives the destination address with `vram_we_o` = 1 and `vram_wdata_o` equal to the data returned for that read. The first read cycle appears two cycles after the strobe is sampled.
- R3: A block copy started with `len_i` = 0xFFFF moves no word and never asserts `busy_o`. It still completes and may raise the block flag.
- R4: Control bit 2 = 1 steps the source by -1 per word, and 0 steps it by +1. Control bit 3 does the same for the destination. Addresses are 15 bits wide and wrap: 0x0000 - 1 = 0x7FFF.
- R5: If control bit 1 is 1 when a block copy completes, `blk_done_o` and `irq_o` become 1 in the cycle after the last write. Otherwise `blk_done_o` stays 0.
- R6: Once armed, the sprite table copy reads VRAM addresses base+0 to base+255 in order. Each read is followed by one cycle with `sat_we_o` = 1, `sat_idx_o` = i and the read data. The first read comes two cycles after the trigger pulse is sampled.
- R7: With control bit 4 = 1, every `vblank_i` pulse triggers a sprite table copy without a request.
- R8: A trigger pulse while `sat_base_i` > 0x7F00 does nothing, and any pending request is kept. A later pulse with the base at 0x7F00 or below runs the copy.
- R9: A completed sprite table copy sets `sat_seen_o`. It also sets `sat_done_o` and `irq_o` if control bit 0 is 1. A pulse on `flag_clr_i` clears all three flags.
- R10: `busy_o` is 1 for exactly the read and write cycles of a copy. A `blk_start_i` pulse that arrives during a copy is kept and served one idle cycle after the copy ends, using the register values present at that time.
- R11: If a block request and an armed sprite copy are both waiting while the engine is idle, the sprite copy runs first and the block copy follows.
- R12: A sprite table request alone causes no VRAM access until a `vblank_i` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 5 | Control: [0] sprite flag enable, [1] block flag enable, [2] source decrement, [3] destination decrement, [4] sprite auto-repeat |
| src_i | input | 15 | Block source address |
| dst_i | input | 15 | Block destination address |
| len_i | input | 16 | Block length (words minus one) |
| sat_base_i | input | 16 | Sprite table base address in VRAM |
| blk_start_i | input | 1 | Block copy request strobe |
| sat_start_i | input | 1 | Sprite table copy request strobe |
| vblank_i | input | 1 | Sprite copy trigger pulse |
| flag_clr_i | input | 1 | Clears completion flags |
| vram_addr_o | output | 15 | VRAM address |
| vram_we_o | output | 1 | VRAM write enable |
| vram_wdata_o | output | 16 | VRAM write data |
| vram_rdata_i | input | 16 | VRAM read data, one cycle after address |
| sat_we_o | output | 1 | Attribute store write enable |
| sat_idx_o | output | 8 | Attribute store index |
| sat_wdata_o | output | 16 | Attribute store write data |
| busy_o | output | 1 | Copy in progress |
| blk_done_o | output | 1 | Block copy done flag |
| sat_done_o | output | 1 | Sprite copy done flag |
| sat_seen_o | output | 1 | Sprite copy performed |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong address stepper or a wrong length counter shows up on `vram_addr_o`, or as one word too many or too few, within the same copy. The bench compares every cycle against a trace model, so such a fault is reported in the first cycle where the trace differs. A lost or duplicated request changes when `busy_o` rises, so the fault shows two cycles after the strobe or after the copy ends. Flag faults are only visible at the points where the bench samples the flags after each copy. Data corruption is caught when the bench compares the whole VRAM image and the attribute store against reference copies.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRD,
    ST_BWR,
    ST_SRD,
    ST_SWR
  } vdma_state_e;

  // control bit positions
  localparam int unsigned CB_SAT_IE   = 0;
  localparam int unsigned CB_BLK_IE   = 1;
  localparam int unsigned CB_SRC_DEC  = 2;
  localparam int unsigned CB_DST_DEC  = 3;
  localparam int unsigned CB_SAT_AUTO = 4;
  localparam int unsigned CTRL_W      = 5;
endpackage

// File: rtl/vdma_req.sv
module vdma_req #(
  parameter int unsigned AW           = 15,
  parameter int unsigned DW           = 16,
  parameter logic [DW-1:0] SAT_MAX_BASE = 16'h7F00
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          blk_start_i,
  input  logic          sat_start_i,
  input  logic          vblank_i,
  input  logic          auto_i,
  input  logic [DW-1:0] sat_base_i,
  input  logic          blk_take_i,
  input  logic          sat_take_i,
  output logic          blk_req_o,
  output logic          sat_go_o,
  output logic [AW-1:0] sat_base_o
);
  logic          blk_req_q, sat_req_q, sat_go_q, arm;
  logic [AW-1:0] base_q;

  assign arm = vblank_i && !sat_go_q && (sat_req_q || auto_i) && (sat_base_i <= SAT_MAX_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_req_q <= 1'b0;
      sat_req_q <= 1'b0;
      sat_go_q  <= 1'b0;
      base_q    <= '0;
    end else begin
      blk_req_q <= blk_start_i | (blk_req_q & ~blk_take_i);
      sat_req_q <= sat_start_i | (sat_req_q & ~sat_take_i);
      if (arm) begin
        sat_go_q <= 1'b1;
        base_q   <= sat_base_i[AW-1:0];
      end else if (sat_take_i) begin
        sat_go_q <= 1'b0;
      end
    end
  end

  assign blk_req_o  = blk_req_q;
  assign sat_go_o   = sat_go_q;
  assign sat_base_o = base_q;

  AST_ARM_ON_VBLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_go_q) |-> $past(vblank_i)); // R12
  AST_TAKE_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_take_i |-> sat_go_q); // R8
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
  import vdma_pkg::*;
#(
  parameter int unsigned AW        = 15,
  parameter int unsigned DW        = 16,
  parameter int unsigned SAT_WORDS = 256,
  localparam int unsigned SIW      = $clog2(SAT_WORDS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           blk_req_i,
  input  logic           sat_go_i,
  input  logic [AW-1:0]  src_i,
  input  logic [AW-1:0]  dst_i,
  input  logic [DW-1:0]  len_i,
  input  logic           src_dec_i,
  input  logic           dst_dec_i,
  input  logic [AW-1:0]  sat_base_i,
  input  logic [DW-1:0]  vram_rdata_i,
  output logic           blk_take_o,
  output logic           blk_fin_o,
  output logic           sat_take_o,
  output logic           sat_fin_o,
  output logic           busy_o,
  output logic [AW-1:0]  vram_addr_o,
  output logic           vram_we_o,
  output logic [DW-1:0]  vram_wdata_o,
  output logic           sat_we_o,
  output logic [SIW-1:0] sat_idx_o,
  output logic [DW-1:0]  sat_wdata_o
);
  vdma_state_e    state_q;
  logic [AW-1:0]  src_q, dst_q, sbase_q;
  logic [DW-1:0]  cnt_q;
  logic [SIW-1:0] idx_q;
  logic           sdec_q, ddec_q;
  logic           zero_len, last_word, last_entry;

  assign zero_len   = (len_i == '1);
  assign last_word  = (cnt_q == '0);
  assign last_entry = (idx_q == SIW'(SAT_WORDS - 1));

  always_comb begin
    blk_take_o = 1'b0;
    blk_fin_o  = 1'b0;
    sat_take_o = 1'b0;
    sat_fin_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sat_go_i) sat_take_o = 1'b1;
        else if (blk_req_i) begin
          blk_take_o = 1'b1;
          blk_fin_o  = zero_len;
        end
      end
      ST_BWR:  blk_fin_o = last_word;
      ST_SWR:  sat_fin_o = last_entry;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      sbase_q <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      sdec_q  <= 1'b0;
      ddec_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (sat_go_i) begin
            idx_q   <= '0;
            sbase_q <= sat_base_i;
            state_q <= ST_SRD;
          end else if (blk_req_i && !zero_len) begin
            src_q   <= src_i;
            dst_q   <= dst_i;
            cnt_q   <= len_i;
            sdec_q  <= src_dec_i;
            ddec_q  <= dst_dec_i;
            state_q <= ST_BRD;
          end
        end
        ST_BRD: state_q <= ST_BWR;
        ST_BWR: begin
          src_q   <= sdec_q ? src_q - 1'b1 : src_q + 1'b1;
          dst_q   <= ddec_q ? dst_q - 1'b1 : dst_q + 1'b1;
          cnt_q   <= cnt_q - 1'b1;
          state_q <= last_word ? ST_IDLE : ST_BRD;
        end
        ST_SRD: state_q <= ST_SWR;
        ST_SWR: begin
          idx_q   <= idx_q + 1'b1;
          state_q <= last_entry ? ST_IDLE : ST_SRD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_BRD:          vram_addr_o = src_q;
      ST_BWR:          vram_addr_o = dst_q;
      ST_SRD, ST_SWR:  vram_addr_o = sbase_q + AW'(idx_q);
      default:         vram_addr_o = '0;
    endcase
  end

  assign vram_we_o    = (state_q == ST_BWR);
  assign vram_wdata_o = vram_rdata_i;
  assign sat_we_o     = (state_q == ST_SWR);
  assign sat_idx_o    = idx_q;
  assign sat_wdata_o  = vram_rdata_i;
  assign busy_o       = (state_q != ST_IDLE);

  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o |-> $past(state_q) == ST_BRD); // R2
  AST_ONE_SINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vram_we_o && sat_we_o)); // R6
  AST_SAT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_we_o |=> !sat_we_o); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !vram_we_o && !sat_we_o); // R10
  AST_SAT_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_go_i && blk_req_i && !busy_o) |=> state_q == ST_SRD); // R11
endmodule

// File: rtl/vdma_flags.sv
module vdma_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_fin_i,
  input  logic sat_fin_i,
  input  logic blk_ie_i,
  input  logic sat_ie_i,
  input  logic clr_i,
  output logic blk_done_o,
  output logic sat_done_o,
  output logic sat_seen_o,
  output logic irq_o
);
  logic blk_q, sat_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q  <= 1'b0;
      sat_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      blk_q  <= (blk_fin_i && blk_ie_i) || (blk_q && !clr_i);
      sat_q  <= (sat_fin_i && sat_ie_i) || (sat_q && !clr_i);
      seen_q <= sat_fin_i || (seen_q && !clr_i);
    end
  end

  assign blk_done_o = blk_q;
  assign sat_done_o = sat_q;
  assign sat_seen_o = seen_q;
  assign irq_o      = blk_q | sat_q;

  AST_BLK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_q && !clr_i) |=> blk_q); // R5
  AST_CLR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !blk_fin_i && !sat_fin_i) |=> !irq_o && !sat_seen_o); // R9
endmodule

// File: rtl/vram_dma.sv
module vram_dma
  import vdma_pkg::*;
#(
  parameter int unsigned   AW           = 15,
  parameter int unsigned   DW           = 16,
  parameter int unsigned   SAT_WORDS    = 256,
  parameter logic [DW-1:0] SAT_MAX_BASE = 16'h7F00,
  localparam int unsigned  SIW          = $clog2(SAT_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [DW-1:0]     len_i,
  input  logic [DW-1:0]     sat_base_i,
  input  logic              blk_start_i,
  input  logic              sat_start_i,
  input  logic              vblank_i,
  input  logic              flag_clr_i,
  output logic [AW-1:0]     vram_addr_o,
  output logic              vram_we_o,
  output logic [DW-1:0]     vram_wdata_o,
  input  logic [DW-1:0]     vram_rdata_i,
  output logic              sat_we_o,
  output logic [SIW-1:0]    sat_idx_o,
  output logic [DW-1:0]     sat_wdata_o,
  output logic              busy_o,
  output logic              blk_done_o,
  output logic              sat_done_o,
  output logic              sat_seen_o,
  output logic              irq_o
);
  logic          blk_req, sat_go, blk_take, sat_take, blk_fin, sat_fin;
  logic [AW-1:0] sat_base;

  vdma_req #(.AW(AW), .DW(DW), .SAT_MAX_BASE(SAT_MAX_BASE)) i_req (
    .clk_i, .rst_ni,
    .blk_start_i, .sat_start_i, .vblank_i,
    .auto_i     (ctrl_i[CB_SAT_AUTO]),
    .sat_base_i,
    .blk_take_i (blk_take),
    .sat_take_i (sat_take),
    .blk_req_o  (blk_req),
    .sat_go_o   (sat_go),
    .sat_base_o (sat_base)
  );

  vdma_seq #(.AW(AW), .DW(DW), .SAT_WORDS(SAT_WORDS)) i_seq (
    .clk_i, .rst_ni,
    .blk_req_i  (blk_req),
    .sat_go_i   (sat_go),
    .src_i, .dst_i, .len_i,
    .src_dec_i  (ctrl_i[CB_SRC_DEC]),
    .dst_dec_i  (ctrl_i[CB_DST_DEC]),
    .sat_base_i (sat_base),
    .vram_rdata_i,
    .blk_take_o (blk_take),
    .blk_fin_o  (blk_fin),
    .sat_take_o (sat_take),
    .sat_fin_o  (sat_fin),
    .busy_o,
    .vram_addr_o, .vram_we_o, .vram_wdata_o,
    .sat_we_o, .sat_idx_o, .sat_wdata_o
  );

  vdma_flags i_flags (
    .clk_i, .rst_ni,
    .blk_fin_i  (blk_fin),
    .sat_fin_i  (sat_fin),
    .blk_ie_i   (ctrl_i[CB_BLK_IE]),
    .sat_ie_i   (ctrl_i[CB_SAT_IE]),
    .clr_i      (flag_clr_i),
    .blk_done_o, .sat_done_o, .sat_seen_o, .irq_o
  );

  AST_ZERO_LEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_take && len_i == '1 && !sat_go) |=> !busy_o); // R3
endmodule

// File: tb/test_vram_dma.sv
`timescale 1ns/100ps
module test_vram_dma;
  typedef struct packed {
    logic        busy;
    logic        we;
    logic [14:0] addr;
    logic        swe;
    logic [7:0]  sidx;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ctrl = '0;
  logic [14:0] src = '0, dst = '0;
  logic [15:0] len = '0, sbase = '0;
  logic        blk_start = 0, sat_start = 0, vblank = 0, fclr = 0;
  logic [14:0] vaddr;
  logic        vwe, swe, busy, bdone, sdone, sseen, irq;
  logic [15:0] vwdata, vrdata, swdata;
  logic [7:0]  sidx;

  logic [15:0] mem [0:32767];
  logic [15:0] ref_mem [0:32767];
  logic [15:0] sat_mem [0:255];
  logic [15:0] ref_sat [0:255];
  exp_t        q[$];
  int          errors = 0, checks = 0;
  string       cur_req = "R1";
  bit          cmp_on = 0;

  always #2.5 clk = ~clk;

  vram_dma i_vram_dma (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .src_i(src), .dst_i(dst),
    .len_i(len), .sat_base_i(sbase), .blk_start_i(blk_start),
    .sat_start_i(sat_start), .vblank_i(vblank), .flag_clr_i(fclr),
    .vram_addr_o(vaddr), .vram_we_o(vwe), .vram_wdata_o(vwdata),
    .vram_rdata_i(vrdata), .sat_we_o(swe), .sat_idx_o(sidx),
    .sat_wdata_o(swdata), .busy_o(busy), .blk_done_o(bdone),
    .sat_done_o(sdone), .sat_seen_o(sseen), .irq_o(irq)
  );

  always @(posedge clk) begin
    if (vwe) mem[vaddr] <= vwdata;
    vrdata <= mem[vaddr];
    if (swe) sat_mem[sidx] <= swdata;
  end

  // per-cycle trace comparison
  always @(posedge clk) begin
    #1.5;
    if (rst_n && cmp_on) begin
      exp_t e;
      bit   bad;
      e = (q.size() > 0) ? q.pop_front() : '0;
      bad = (busy !== e.busy) || (vwe !== e.we) || (swe !== e.swe) ||
            (e.busy && vaddr !== e.addr) || (e.swe && sidx !== e.sidx);
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s trace: actual busy=%b we=%b addr=%h swe=%b idx=%0d expected busy=%b we=%b addr=%h swe=%b idx=%0d",
                 cur_req, busy, vwe, vaddr, swe, sidx, e.busy, e.we, e.addr, e.swe, e.sidx);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) q.push_back('0);
  endtask

  task automatic push_blk(input int s, input int d, input int n, input bit sdec, input bit ddec);
    for (int k = 0; k <= n; k++) begin
      q.push_back('{1'b1, 1'b0, 15'(s), 1'b0, 8'd0});
      q.push_back('{1'b1, 1'b1, 15'(d), 1'b0, 8'd0});
      ref_mem[d] = ref_mem[s];
      s = (sdec ? s - 1 : s + 1) & 32'h7FFF;
      d = (ddec ? d - 1 : d + 1) & 32'h7FFF;
    end
  endtask

  task automatic push_sat(input int base);
    for (int i = 0; i < 256; i++) begin
      q.push_back('{1'b1, 1'b0, 15'(base + i), 1'b0, 8'd0});
      q.push_back('{1'b1, 1'b0, 15'(base + i), 1'b1, 8'(i)});
      ref_sat[i] = ref_mem[base + i];
    end
  endtask

  task automatic blk_go(input int s, input int d, input int n);
    @(negedge clk);
    src = 15'(s); dst = 15'(d); len = 16'(n);
    blk_start = 1;
    push_idle(1);
    if (n != 16'hFFFF) push_blk(s & 32'h7FFF, d & 32'h7FFF, n, ctrl[2], ctrl[3]);
    @(negedge clk);
    blk_start = 0;
  endtask

  task automatic vb_pulse();
    @(negedge clk); vblank = 1;
    @(negedge clk); vblank = 0;
  endtask

  task automatic wait_idle();
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); fclr = 1;
    @(negedge clk); fclr = 0;
  endtask

  task automatic chk_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < 32768; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk({tag, " vram image mismatches"}, bad, 0);
  endtask

  task automatic chk_sat(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (sat_mem[i] !== ref_sat[i]) bad++;
    chk({tag, " attribute store mismatches"}, bad, 0);
  endtask

  task automatic run_all();
    // R1 reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 flags", {bdone, sdone, sseen, irq}, 0);

    // R2, R5 forward copy with flag enabled
    cur_req = "R2";
    ctrl = 5'b00010;
    blk_go(15'h0100, 15'h0200, 3);
    wait_idle();
    chk("R5 blk_done", bdone, 1);
    chk("R5 irq", irq, 1);
    chk_mem("R2");

    // R9 clear
    clear_flags();
    @(negedge clk);
    chk("R9 clear blk_done", bdone, 0);
    chk("R9 clear irq", irq, 0);

    // R4 decrementing source with wrap, destination masked
    cur_req = "R4";
    ctrl = 5'b00100;
    blk_go(15'h0001, 15'h0010, 3);
    wait_idle();
    chk_mem("R4");
    chk("R5 no flag when disabled", bdone, 0);

    // R4 decrementing destination
    ctrl = 5'b01000;
    blk_go(15'h0300, 15'h7FFE, 4);
    wait_idle();
    chk_mem("R4 dst");

    // R3 zero-length
    cur_req = "R3";
    ctrl = 5'b00010;
    blk_go(15'h0400, 15'h0500, 16'hFFFF);
    wait_idle();
    chk("R3 flag on empty copy", bdone, 1);
    chk_mem("R3");
    clear_flags();

    // R10 start during copy is queued
    cur_req = "R10";
    ctrl = 5'b00000;
    blk_go(15'h0600, 15'h0700, 2);
    @(negedge clk);
    src = 15'h0800; dst = 15'h0900; len = 16'd1;
    blk_start = 1;
    push_idle(1);
    push_blk(15'h0800, 15'h0900, 1, 1'b0, 1'b0);
    @(negedge clk);
    blk_start = 0;
    wait_idle();
    chk_mem("R10");

    // R12 request alone does nothing; R6, R9 sprite copy
    cur_req = "R12";
    ctrl = 5'b00001;
    sbase = 16'h0400;
    @(negedge clk); sat_start = 1;
    @(negedge clk); sat_start = 0;
    repeat (6) @(negedge clk);
    chk("R12 no copy before trigger", sseen, 0);
    cur_req = "R6";
    @(negedge clk); vblank = 1; push_idle(1); push_sat(32'h0400);
    @(negedge clk); vblank = 0;
    wait_idle();
    chk_sat("R6");
    chk("R9 sat_done", sdone, 1);
    chk("R9 sat_seen", sseen, 1);
    chk("R9 irq", irq, 1);
    clear_flags();
    @(negedge clk);
    chk("R9 cleared", {sdone, sseen, irq}, 0);

    // R8 base over limit, request kept
    cur_req = "R8";
    ctrl = 5'b00000;
    sbase = 16'h7F01;
    @(negedge clk); sat_start = 1;
    @(negedge clk); sat_start = 0;
    vb_pulse();
    repeat (4) @(negedge clk);
    chk("R8 rejected base", sseen, 0);
    sbase = 16'h7F00;
    @(negedge clk); vblank = 1; push_idle(1); push_sat(32'h7F00);
    @(negedge clk); vblank = 0;
    wait_idle();
    chk_sat("R8");
    chk("R8 seen", sseen, 1);
    chk("R9 no sat_done when disabled", sdone, 0);
    clear_flags();

    // R7 auto repeat
    cur_req = "R7";
    ctrl = 5'b10000;
    sbase = 16'h0123;
    @(negedge clk); vblank = 1; push_idle(1); push_sat(32'h0123);
    @(negedge clk); vblank = 0;
    wait_idle();
    chk_sat("R7 first");
    sbase = 16'h0200;
    @(negedge clk); vblank = 1; push_idle(1); push_sat(32'h0200);
    @(negedge clk); vblank = 0;
    wait_idle();
    chk_sat("R7 second");

    // R11 sprite copy wins over block copy
    cur_req = "R11";
    ctrl = 5'b10010;
    sbase = 16'h0050;
    src = 15'h1000; dst = 15'h2000; len = 16'd2;
    @(negedge clk);
    vblank = 1; blk_start = 1;
    push_idle(1);
    push_sat(32'h0050);
    push_idle(1);
    push_blk(32'h1000, 32'h2000, 2, 1'b0, 1'b0);
    @(negedge clk);
    vblank = 0; blk_start = 0;
    ctrl = 5'b00010;
    wait_idle();
    chk_sat("R11");
    chk_mem("R11");
    chk("R11 blk_done", bdone, 1);
    ctrl = 5'b00000;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) begin
      mem[i]     = 16'((i * 7 + 3) ^ (i >> 5));
      ref_mem[i] = 16'((i * 7 + 3) ^ (i >> 5));
    end
    for (int i = 0; i < 256; i++) begin
      sat_mem[i] = '0;
      ref_sat[i] = '0;
    end
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL %s watchdog: actual=hung expected=done", cur_req);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule